// File: doc/BRIEF.md
# Frequency Hopping Channel Sequencer

The block schedules transmit slots for a frequency-hopping radio link and says, for every slot, which carrier to use. The carrier set is 27 channels on a fixed grid spaced 499712 Hz apart. Two further table positions repeat grid channels picked by a pseudo-random stride, so the table has 29 positions. Two bands are supported, and each has its own grid origin.

An initialisation pulse samples a free-running LFSR to pick the stride, latches the band, resets the table position to zero and restarts the slot timer. Each time the timer fires, the block takes the current table position, maps it to a grid channel and works out that channel's frequency. It divides the frequency by 61 with a serial divider to form the 24-bit synthesizer word, then steps the position forward by the stride, wrapping modulo 29. The word is ready well before the next slot. The radio register writes and the frame contents are left to other logic.

Top module: `hop_sequencer`

## Requirements
- R1: After reset all outputs are zero, and no `slot_tick` or `out_valid` appears until the first `init` pulse.
- R2: At `init` the stride is set to 1 + (LFSR value mod 24), so it always lies in 1..24. It stays constant on `out_step` until the next `init`.
- R3: The first `slot_tick` is high in the cycle that begins FIRST_CYC clock edges after the edge that samples `init`.
- R4: Every later `slot_tick` follows the previous one by exactly PERIOD_CYC cycles, and each is high for a single cycle.
- R5: The first slot after `init` reports `out_index` 0. Each following slot reports (previous index + stride) mod 29.
- R6: Table positions 0..26 select grid channel equal to the position. Position 27 selects grid channel equal to the stride, and position 28 selects grid channel stride+1. The slot frequency is base + channel × 499712 Hz.
- R7: `band_sel` is sampled only at `init`: 0 selects base 914472960 Hz and 1 selects base 859504640 Hz. Changes of `band_sel` at other times have no effect on the words produced.
- R8: `out_word` equals floor(frequency / 61) as 24 bits. Bits [23:16] form the byte sent first and bits [7:0] the byte sent last.
- R9: `out_valid` pulses for one cycle exactly once per slot, 31 cycles after that slot's `slot_tick`. `out_index`, `out_step` and `out_word` are valid while it is high.
- R10: An `init` during a slot discards that slot's pending result, so no `out_valid` appears before the new first slot. The sequence restarts at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | One-cycle pulse that picks a stride, latches the band and restarts the slots |
| band_sel | input | 1 | Band choice, sampled at `init` (0 upper band, 1 lower band) |
| slot_tick | output | 1 | One-cycle slot start marker |
| out_valid | output | 1 | One-cycle marker that the slot results are ready |
| out_index | output | 5 | Hop table position of the reported slot |
| out_step | output | 5 | Current stride |
| out_word | output | 24 | Synthesizer frequency word, most significant byte first |

## Verification
A corrupted position register or modulo wrap shows up at the very next `out_valid` as a wrong `out_index`, and the error stays in every later slot because each index depends on the previous one. A wrong channel mapping for the two extra positions only appears when the walk reaches positions 27 and 28. Every stride is coprime with 29, so a full 29-slot walk visits both of those positions. A divider that is late or has a bad iteration count moves `out_valid` away from its fixed 31-cycle offset, or gives a word that differs from the arithmetic quotient on the first slot. Timer faults show up as soon as the first tick after `init`.

// File: rtl/hop_pkg.sv
package hop_pkg;
    localparam int HOP_LEN    = 29;
    localparam int GRID_LEN   = 27;
    localparam int STEP_SPAN  = 24;
    localparam int IDX_W      = 5;
    localparam int IDXP_W     = IDX_W + 1;
    localparam int FREQ_W     = 30;
    localparam int WORD_W     = 24;
    localparam int SPACING_HZ = 499712;
    localparam int DIVISOR    = 61;
    localparam int RND_W      = 16;
    localparam logic [FREQ_W-1:0] BASE_UPPER = 30'd914472960;
    localparam logic [FREQ_W-1:0] BASE_LOWER = 30'd859504640;

    typedef enum logic {BAND_UPPER = 1'b0, BAND_LOWER = 1'b1} band_e;

    typedef struct packed {
        logic [IDX_W-1:0]  index;
        logic [IDX_W-1:0]  step;
        logic [WORD_W-1:0] word;
    } slot_rec_t;

    function automatic logic [IDX_W-1:0] pick_step(input logic [RND_W-1:0] r);
        logic [RND_W-1:0] m;
        m = r % RND_W'(STEP_SPAN);
        return IDX_W'(m) + IDX_W'(1);
    endfunction

    function automatic logic [IDX_W-1:0] grid_channel(input logic [IDX_W-1:0] pos,
                                                      input logic [IDX_W-1:0] step);
        if (pos < IDX_W'(GRID_LEN))
            return pos;
        else if (pos == IDX_W'(GRID_LEN))
            return step;
        else
            return step + IDX_W'(1);
    endfunction

    function automatic logic [FREQ_W-1:0] channel_hz(input band_e b,
                                                     input logic [IDX_W-1:0] ch);
        logic [FREQ_W-1:0] base;
        base = (b == BAND_LOWER) ? BASE_LOWER : BASE_UPPER;
        return base + FREQ_W'(ch) * FREQ_W'(SPACING_HZ);
    endfunction

    function automatic logic [IDX_W-1:0] advance(input logic [IDX_W-1:0] pos,
                                                 input logic [IDX_W-1:0] step);
        logic [IDXP_W-1:0] s;
        s = {1'b0, pos} + {1'b0, step};
        if (s >= IDXP_W'(HOP_LEN))
            s = s - IDXP_W'(HOP_LEN);
        return s[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/hop_lfsr.sv
module hop_lfsr #(
    parameter int W = 16,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)
            value <= SEED;
        else
            value <= {1'b0, value[W-1:1]} ^ (value[0] ? TAPS : '0);
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        value != '0);                                                   // R2
endmodule

// File: rtl/hop_slot_timer.sv
module hop_slot_timer #(
    parameter int FIRST_CYC  = 2500000,
    parameter int PERIOD_CYC = 2425000
) (
    input  logic clk,
    input  logic rst,
    input  logic init,
    output logic tick,
    output logic running
);
    localparam int MAXC = (FIRST_CYC > PERIOD_CYC) ? FIRST_CYC : PERIOD_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
            tick    <= 1'b0;
        end else if (init) begin
            cnt     <= CW'(FIRST_CYC - 1);
            running <= 1'b1;
            tick    <= 1'b0;
        end else if (running) begin
            if (cnt == '0) begin
                tick <= 1'b1;
                cnt  <= CW'(PERIOD_CYC - 1);
            end else begin
                tick <= 1'b0;
                cnt  <= cnt - CW'(1);
            end
        end else begin
            tick <= 1'b0;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);                                                // R4
endmodule

// File: rtl/hop_div.sv
module hop_div #(
    parameter int DVD_W = 30,
    parameter int DVS   = 61,
    parameter int Q_W   = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    output logic             busy,
    output logic             done,
    output logic [Q_W-1:0]   quotient
);
    localparam int REM_W = $clog2(DVS) + 1;
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [REM_W-1:0] rem, trial, rem_nx;
    logic [DVD_W-1:0] sh, sh_nx, keep;
    logic [CNT_W-1:0] cnt;
    logic             ge;

    always_comb begin
        trial  = {rem[REM_W-2:0], sh[DVD_W-1]};
        ge     = (trial >= REM_W'(DVS));
        rem_nx = ge ? trial - REM_W'(DVS) : trial;
        sh_nx  = {sh[DVD_W-2:0], ge};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rem      <= '0;
            sh       <= '0;
            keep     <= '0;
            cnt      <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            quotient <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                sh   <= dividend;
                keep <= dividend;
                rem  <= '0;
                cnt  <= CNT_W'(DVD_W);
                busy <= 1'b1;
            end else if (busy) begin
                rem <= rem_nx;
                sh  <= sh_nx;
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    quotient <= sh_nx[Q_W-1:0];
                end
            end
        end
    end

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (rst)
        done |-> (64'(sh) * 64'(DVS) + 64'(rem) == 64'(keep)) && (rem < REM_W'(DVS)));  // R8
    AST_QUO_FITS: assert property (@(posedge clk) disable iff (rst)
        done |-> (sh[DVD_W-1:Q_W] == '0));                             // R8
endmodule

// File: rtl/hop_sequencer.sv
module hop_sequencer
    import hop_pkg::*;
#(
    parameter int FIRST_CYC  = 2500000,
    parameter int PERIOD_CYC = 2425000,
    parameter logic [RND_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              band_sel,
    output logic              slot_tick,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_index,
    output logic [IDX_W-1:0]  out_step,
    output logic [WORD_W-1:0] out_word
);
    logic [RND_W-1:0]  rnd;
    logic              running;
    logic              div_busy, div_done, div_start;
    logic [WORD_W-1:0] div_q;
    logic [FREQ_W-1:0] slot_hz;
    logic [IDX_W-1:0]  pos_q, cur_q, step_q;
    band_e             band_q;
    logic              armed;
    slot_rec_t         rec;

    hop_lfsr #(.W(RND_W), .SEED(LFSR_SEED)) i_lfsr (
        .clk(clk), .rst(rst), .value(rnd)
    );

    hop_slot_timer #(.FIRST_CYC(FIRST_CYC), .PERIOD_CYC(PERIOD_CYC)) i_timer (
        .clk(clk), .rst(rst), .init(init), .tick(slot_tick), .running(running)
    );

    assign div_start = slot_tick && !init;
    assign slot_hz   = channel_hz(band_q, grid_channel(pos_q, step_q));

    hop_div #(.DVD_W(FREQ_W), .DVS(DIVISOR), .Q_W(WORD_W)) i_div (
        .clk(clk), .rst(rst), .clr(init), .start(div_start),
        .dividend(slot_hz), .busy(div_busy), .done(div_done), .quotient(div_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            cur_q  <= '0;
            step_q <= '0;
            band_q <= BAND_UPPER;
            armed  <= 1'b0;
        end else if (init) begin
            pos_q  <= '0;
            cur_q  <= '0;
            step_q <= pick_step(rnd);
            band_q <= band_e'(band_sel);
            armed  <= 1'b1;
        end else if (slot_tick) begin
            cur_q <= pos_q;
            pos_q <= advance(pos_q, step_q);
        end
    end

    assign rec       = '{index: cur_q, step: step_q, word: div_q};
    assign out_valid = div_done;
    assign out_index = rec.index;
    assign out_step  = rec.step;
    assign out_word  = rec.word;

    AST_NO_TICK_UNARMED: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !slot_tick && !running);                             // R1
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        armed |-> (step_q >= IDX_W'(1)) && (step_q <= IDX_W'(STEP_SPAN))); // R2
    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (pos_q < IDX_W'(HOP_LEN)) && (cur_q < IDX_W'(HOP_LEN)));        // R5
    AST_DIV_IDLE_AT_TICK: assert property (@(posedge clk) disable iff (rst)
        slot_tick |-> !div_busy);                                       // R9
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);                                      // R9
endmodule

// File: tb/test_hop_sequencer.sv
module test_hop_sequencer;
    localparam int F   = 48;
    localparam int P   = 40;
    localparam int LAT = 31;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init = 1'b0;
    logic        band_sel = 1'b0;
    logic        slot_tick, out_valid;
    logic [4:0]  out_index, out_step;
    logic [23:0] out_word;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    bit  seen_step [25];

    hop_sequencer #(.FIRST_CYC(F), .PERIOD_CYC(P)) i_hop_sequencer (
        .clk(clk), .rst(rst), .init(init), .band_sel(band_sel),
        .slot_tick(slot_tick), .out_valid(out_valid), .out_index(out_index),
        .out_step(out_step), .out_word(out_word)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic longint expect_word(input bit band, input int pos, input int step);
        longint base;
        int ch;
        base = band ? 64'd859504640 : 64'd914472960;
        ch = (pos < 27) ? pos : ((pos == 27) ? step : step + 1);
        return (base + longint'(ch) * 64'd499712) / 64'd61;
    endfunction

    task automatic run(input bit band, input int slots, input int abort_at);
        int k;
        int step;
        int pos;
        longint exp;
        @(negedge clk);
        band_sel = band;
        init = 1'b1;
        @(negedge clk);
        init = 1'b0;
        band_sel = ~band;   // R7: must be ignored until next init
        k = 1;
        while (!slot_tick) begin
            if (out_valid) chk(1'b0, "R10 stale result after init", 1, 0);
            @(negedge clk);
            k++;
        end
        chk(k == F + 1, "R3 first tick delay", k, F + 1);
        pos = 0;
        step = 0;
        for (int s = 0; s < slots; s++) begin
            if (s == abort_at) begin
                repeat (10) @(negedge clk);
                return;
            end
            k = 0;
            while (!out_valid) begin
                @(negedge clk);
                k++;
            end
            chk(k == LAT, "R9 result latency", k, LAT);
            if (s == 0) begin
                step = int'(out_step);
                chk(out_index == 5'd0, "R10 restart at position 0", out_index, 0);
            end
            chk(out_step >= 5'd1 && out_step <= 5'd24, "R2 stride range", out_step, 1);
            chk(int'(out_step) == step, "R2 stride held", out_step, step);
            if (step >= 1 && step <= 24) seen_step[step] = 1'b1;
            chk(int'(out_index) == pos, "R5 position sequence", out_index, pos);
            exp = expect_word(band, pos, step);
            chk(longint'(out_word) == exp, "R6 R7 word value", out_word, exp);
            chk(longint'(out_word[23:16]) == (exp >> 16), "R8 leading byte", out_word[23:16], exp >> 16);
            @(negedge clk);
            k++;
            chk(!out_valid, "R9 valid one cycle", out_valid, 0);
            while (!slot_tick) begin
                if (out_valid) chk(1'b0, "R9 extra valid", 1, 0);
                @(negedge clk);
                k++;
            end
            chk(k == P, "R4 slot period", k, P);
            pos = (pos + step) % 29;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!slot_tick && !out_valid, "R1 reset flags", {slot_tick, out_valid}, 0);
        chk(out_index == 0 && out_step == 0, "R1 reset index and stride", {out_index, out_step}, 0);
        chk(out_word == 0, "R1 reset word", out_word, 0);
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (slot_tick || out_valid) chk(1'b0, "R1 activity before init", 1, 0);
        end
        for (int r = 0; r < 40; r++) begin
            repeat ((r * 7) % 13) @(negedge clk);
            run(r[0], 30, (r % 5 == 3) ? 4 : 1000);
        end
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end
endmodule